// File: doc/BRIEF.md
# Windowed Host Port for Coprocessor Memory

This block lets a host processor reach a coprocessor's data store and instruction store through a handful of 16-bit registers rather than through a wide address window. The host first loads a 32-bit memory pointer in two halves. It then moves words through data registers. When the memory-increment control is on, each data register access moves the pointer forward by itself, so a block transfer needs only one pointer setup.

Bit 22 of the pointer selects instruction space. Instruction word N sits at pointer value (N << 2) with bit 22 set. Its low half is at that pointer value and its high half is two locations above it. The host moves the low half through a dedicated register and the high half through the shared data register, and the pointer steps by four only after the high half. A separate read-and-clear register returns a data word and leaves zero in its place.

The memory side is a plain synchronous single-port interface. A request with write enable low returns data one or more cycles later, marked by a valid strobe. The host side uses a select/read/write handshake. The port holds `host_ready` low on reads of memory-backed registers until the data is present.

Top module: `hwin_port`

## Requirements
- R1: After reset the pointer reads 0 through both pointer registers, the control register reads 0, and `busy` is low.
- R2: Register index 0 reads and writes pointer bits 15:0, and index 1 reads and writes pointer bits 31:16. The pointer changes only through these writes or through an advance after a memory access.
- R3: When pointer bit 22 is clear, index 2 reads and writes the 16-bit memory word at exactly the pointer value.
- R4: When pointer bit 22 is set, index 3 accesses the memory word at the pointer value (the low half) and index 2 accesses the word at pointer+2 (the high half).
- R5: Control bit 0 is the memory-increment enable. With it set, each completed access through index 2, and each read through index 4, adds 1 to the pointer when bit 22 is clear and adds 4 when bit 22 is set. Accesses through index 3 never move the pointer.
- R6: With control bit 0 clear, memory accesses leave the pointer unchanged. Control bit 1 (the I/O-increment enable) is stored and read back at index 5, and it has no effect on the memory pointer.
- R7: A read of index 4 returns the word at the pointer and then writes zero to that same memory location. A host write to index 4 is ignored: it causes no memory write and no pointer change.
- R8: `busy` is high while a memory-side access is in progress. A read of index 2, 3 or 4 holds `host_ready` low until the memory data has arrived.
- R9: Writes to pointer and control registers, and writes to index 2 or 3 from an idle port, complete with `host_ready` high in the same cycle they are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host access request, held until `host_ready` |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_idx | input | 3 | Register index: 0 pointer low, 1 pointer high, 2 data/high half, 3 instruction low half, 4 read-and-clear, 5 control |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid when `host_ready` is high |
| host_ready | output | 1 | Access completes in this cycle |
| busy | output | 1 | A memory-side access is in progress |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_rvalid | input | 1 | Memory read data valid, one pulse per read request |

## Verification
The checks assume that the host keeps select, strobes, index and write data steady from the cycle it raises `host_sel` until the cycle it sees `host_ready`. They also assume that the memory answers each read request with exactly one `mem_rvalid` pulse and raises no pulse otherwise. The bench drives the host only through one task that holds the request until ready and then drops it. Its memory model pulses the valid strobe exactly one cycle after each read request, so the clear-after-read and stall properties see only legal traffic.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    RI_PTR_LO = 3'd0,
    RI_PTR_HI = 3'd1,
    RI_DATA   = 3'd2,
    RI_ILOW   = 3'd3,
    RI_RCLR   = 3'd4,
    RI_CTRL   = 3'd5
  } reg_idx_e;

  localparam int CTRL_BITS   = 2;
  localparam int CTRL_MEMINC = 0;
  localparam int CTRL_IOINC  = 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR,
    S_RD,
    S_RWAIT,
    S_CLR,
    S_DONE
  } seq_st_e;
endpackage

// File: rtl/hwp_addr_unit.sv
module hwp_addr_unit #(
  parameter int DW       = 16,
  parameter int AW       = 32,
  parameter int ISEL_BIT = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [DW-1:0] wdata,
  input  logic          adv,
  output logic [AW-1:0] addr_q
);
  localparam int HI_W = AW - DW;
  localparam logic [AW-1:0] DSTEP = AW'(1);
  localparam logic [AW-1:0] ISTEP = AW'(4);

  logic [AW-1:0] addr_d;
  logic          addr_en;

  assign addr_en = ld_lo | ld_hi | adv;

  always_comb begin
    addr_d = addr_q;
    if (ld_lo) begin
      addr_d = {addr_q[AW-1:DW], wdata};
    end else if (ld_hi) begin
      addr_d = {wdata[HI_W-1:0], addr_q[DW-1:0]};
    end else if (adv) begin
      addr_d = addr_q + (addr_q[ISEL_BIT] ? ISTEP : DSTEP);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/hwp_ctrl_reg.sv
module hwp_ctrl_reg #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [NB-1:0] wbits,
  output logic [NB-1:0] bits_q
);
  for (genvar g = 0; g < NB; g++) begin : g_bit
    logic b_d;
    assign b_d = ld ? wbits[g] : bits_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bits_q[g] <= 1'b0;
      end else begin
        bits_q[g] <= b_d;
      end
    end
  end
endmodule

// File: rtl/hwp_seq.sv
module hwp_seq
  import hwp_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 32,
  parameter int ISEL_BIT = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_wr,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [DW-1:0]    req_wdata,
  input  logic [AW-1:0]    addr_q,
  input  logic             mem_inc,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_rvalid,
  output logic             host_ready,
  output logic             reg_acc,
  output logic             adv,
  output logic             busy,
  output logic             done_st,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [DW-1:0]    rbuf_q
);
  localparam logic [AW-1:0] HI_OFF = AW'(2);

  seq_st_e       state_q, state_d;
  logic [AW-1:0] op_addr_q, op_addr_d;
  logic [DW-1:0] op_wdata_q, op_wdata_d;
  logic          op_clr_q, op_clr_d;
  logic          op_adv_q, op_adv_d;
  logic [DW-1:0] rbuf_d;
  logic          op_ld, rbuf_ld;

  logic is_data, is_ilow, is_rclr;
  logic wr_mem, rd_mem, hi_half;

  assign is_data = (req_idx == RI_DATA);
  assign is_ilow = (req_idx == RI_ILOW);
  assign is_rclr = (req_idx == RI_RCLR);
  assign wr_mem  = req_wr & (is_data | is_ilow);
  assign rd_mem  = ~req_wr & (is_data | is_ilow | is_rclr);
  assign hi_half = is_data & addr_q[ISEL_BIT];

  assign op_ld   = (state_q == S_IDLE) & req_valid;
  assign rbuf_ld = (state_q == S_RWAIT) & mem_rvalid;

  always_comb begin
    state_d    = state_q;
    host_ready = 1'b0;
    adv        = 1'b0;
    op_addr_d  = addr_q + (hi_half ? HI_OFF : '0);
    op_wdata_d = req_wdata;
    op_clr_d   = is_rclr;
    op_adv_d   = mem_inc & (is_data | (is_rclr & ~req_wr));
    rbuf_d     = mem_rdata;
    case (state_q)
      S_IDLE: begin
        host_ready = ~(req_valid & rd_mem);
        if (req_valid & wr_mem) begin
          state_d = S_WR;
        end else if (req_valid & rd_mem) begin
          state_d = S_RD;
        end
      end
      S_WR: begin
        adv     = op_adv_q;
        state_d = S_IDLE;
      end
      S_RD: begin
        state_d = S_RWAIT;
      end
      S_RWAIT: begin
        if (mem_rvalid) begin
          state_d = op_clr_q ? S_CLR : S_DONE;
        end
      end
      S_CLR: begin
        state_d = S_DONE;
      end
      S_DONE: begin
        host_ready = 1'b1;
        adv        = op_adv_q;
        state_d    = S_IDLE;
      end
      default: begin
        state_d = S_IDLE;
      end
    endcase
  end

  assign reg_acc   = (state_q == S_IDLE) & req_valid & host_ready;
  assign busy      = (state_q != S_IDLE);
  assign done_st   = (state_q == S_DONE);
  assign mem_req   = (state_q == S_WR) | (state_q == S_RD) | (state_q == S_CLR);
  assign mem_we    = (state_q == S_WR) | (state_q == S_CLR);
  assign mem_addr  = op_addr_q;
  assign mem_wdata = (state_q == S_CLR) ? '0 : op_wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      op_clr_q   <= 1'b0;
      op_adv_q   <= 1'b0;
    end else if (op_ld) begin
      op_addr_q  <= op_addr_d;
      op_wdata_q <= op_wdata_d;
      op_clr_q   <= op_clr_d;
      op_adv_q   <= op_adv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_q <= '0;
    end else if (rbuf_ld) begin
      rbuf_q <= rbuf_d;
    end
  end
endmodule

// File: rtl/hwin_port.sv
module hwin_port
  import hwp_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 32,
  parameter int ISEL_BIT = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  output logic             host_ready,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_rvalid
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[RST_STAGES-1];

  logic                 req_valid, reg_acc, adv, seq_done;
  logic [AW-1:0]        addr_q;
  logic [CTRL_BITS-1:0] ctrl_q;
  logic [DW-1:0]        rbuf_q;
  logic                 mem_inc, io_inc;
  logic                 ld_lo, ld_hi, ld_ctrl;

  assign req_valid = host_sel & (host_wr | host_rd);
  assign ld_lo     = reg_acc & host_wr & (host_idx == RI_PTR_LO);
  assign ld_hi     = reg_acc & host_wr & (host_idx == RI_PTR_HI);
  assign ld_ctrl   = reg_acc & host_wr & (host_idx == RI_CTRL);
  assign mem_inc   = ctrl_q[CTRL_MEMINC];
  assign io_inc    = ctrl_q[CTRL_IOINC];

  hwp_addr_unit #(.DW(DW), .AW(AW), .ISEL_BIT(ISEL_BIT)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ld_lo  (ld_lo),
    .ld_hi  (ld_hi),
    .wdata  (host_wdata),
    .adv    (adv),
    .addr_q (addr_q)
  );

  hwp_ctrl_reg #(.NB(CTRL_BITS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .ld     (ld_ctrl),
    .wbits  (host_wdata[CTRL_BITS-1:0]),
    .bits_q (ctrl_q)
  );

  hwp_seq #(.DW(DW), .AW(AW), .ISEL_BIT(ISEL_BIT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_valid  (req_valid),
    .req_wr     (host_wr),
    .req_idx    (host_idx),
    .req_wdata  (host_wdata),
    .addr_q     (addr_q),
    .mem_inc    (mem_inc),
    .mem_rdata  (mem_rdata),
    .mem_rvalid (mem_rvalid),
    .host_ready (host_ready),
    .reg_acc    (reg_acc),
    .adv        (adv),
    .busy       (busy),
    .done_st    (seq_done),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .rbuf_q     (rbuf_q)
  );

  always_comb begin
    case (host_idx)
      RI_PTR_LO: host_rdata = addr_q[DW-1:0];
      RI_PTR_HI: host_rdata = DW'(addr_q[AW-1:DW]);
      RI_CTRL:   host_rdata = DW'({io_inc, mem_inc});
      default:   host_rdata = rbuf_q;
    endcase
  end
endmodule

// File: rtl/hwin_port_chk.sv
module hwin_port_chk #(
  parameter int DW = 16,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_sel,
  input logic          host_wr,
  input logic          host_rd,
  input logic [2:0]    host_idx,
  input logic          host_ready,
  input logic          busy,
  input logic          seq_done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rvalid,
  input logic [AW-1:0] addr_q,
  input logic          mem_inc
);
  logic ptr_wr;
  assign ptr_wr = host_sel & host_wr & host_ready & (host_idx == 3'd0 || host_idx == 3'd1);

  AST_CLEAR_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && $past(mem_rvalid)) |-> (mem_wdata == '0 && mem_addr == $past(mem_addr))); // R7

  AST_STALL_UNTIL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |-> !host_ready); // R8

  AST_BUSY_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_sel && (host_wr || host_rd))); // R8

  AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(host_sel && host_wr && host_ready)) |=> $stable(addr_q)); // R2

  AST_NO_ADV_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_inc && !ptr_wr) |=> $stable(addr_q)); // R6
endmodule

bind hwin_port hwin_port_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .host_sel   (host_sel),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_idx   (host_idx),
  .host_ready (host_ready),
  .busy       (busy),
  .seq_done   (seq_done),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_rvalid (mem_rvalid),
  .addr_q     (addr_q),
  .mem_inc    (mem_inc)
);

// File: tb/hwin_port_tb.sv
`timescale 1ns/1ps
module hwin_port_tb;
  import hwp_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_sel, host_wr, host_rd;
  logic [2:0]  host_idx;
  logic [15:0] host_wdata, host_rdata;
  logic        host_ready, busy;
  logic        mem_req, mem_we, mem_rvalid;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  hwin_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
  );

  function automatic logic [7:0] mix(input logic [31:0] a);
    return {a[22], a[6:0]};
  endfunction

  logic [15:0] smem [256];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_req & ~mem_we;
      if (mem_req && mem_we)  smem[mix(mem_addr)] <= mem_wdata;
      if (mem_req && !mem_we) mem_rdata <= smem[mix(mem_addr)];
    end
  end

  logic [15:0] ref_mem [256];
  logic [31:0] ref_ptr;
  logic        ref_minc, ref_ioinc;
  int n_tests = 0, n_fail = 0;
  bit done = 0;
  bit last_bsy;
  int last_waits;
  logic [15:0] last_act, last_exp;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ref_op(input logic [2:0] idx, input bit wr, input logic [15:0] wd,
                        output logic [15:0] exp);
    logic [31:0] ea;
    ea  = ref_ptr + (((idx == RI_DATA) && ref_ptr[22]) ? 32'd2 : 32'd0);
    exp = '0;
    case (idx)
      RI_PTR_LO: if (wr) ref_ptr[15:0] = wd; else exp = ref_ptr[15:0];
      RI_PTR_HI: if (wr) ref_ptr[31:16] = wd; else exp = ref_ptr[31:16];
      RI_CTRL:   if (wr) begin ref_minc = wd[0]; ref_ioinc = wd[1]; end
                 else exp = {14'b0, ref_ioinc, ref_minc};
      RI_DATA, RI_ILOW: if (wr) ref_mem[mix(ea)] = wd; else exp = ref_mem[mix(ea)];
      RI_RCLR:   if (!wr) begin exp = ref_mem[mix(ea)]; ref_mem[mix(ea)] = '0; end
      default: ;
    endcase
    if (ref_minc && ((idx == RI_DATA) || (idx == RI_RCLR && !wr)))
      ref_ptr = ref_ptr + (ref_ptr[22] ? 32'd4 : 32'd1);
  endtask

  task automatic access(input logic [2:0] idx, input bit wr, input logic [15:0] wd);
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; host_rd = !wr; host_idx = idx; host_wdata = wd;
    last_bsy = 0; last_waits = 0;
    #1;
    while (!host_ready) begin
      if (busy) last_bsy = 1;
      last_waits++;
      @(negedge clk); #1;
    end
    last_act = host_rdata;
    @(posedge clk); #1;
    host_sel = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
  endtask

  task automatic op(input logic [2:0] idx, input bit wr, input logic [15:0] wd,
                    input string tag, input bit do_chk);
    logic [15:0] e;
    ref_op(idx, wr, wd, e);
    last_exp = e;
    access(idx, wr, wd);
    if (!wr && do_chk) chk(tag, last_act, e);
  endtask

  task automatic set_ptr(input logic [31:0] p);
    op(RI_PTR_LO, 1, p[15:0], "R2", 0);
    op(RI_PTR_HI, 1, p[31:16], "R2", 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      smem[i] = 16'(i * 7 + 3); ref_mem[i] = 16'(i * 7 + 3);
    end
    ref_ptr = '0; ref_minc = 0; ref_ioinc = 0;
    host_sel = 0; host_wr = 0; host_rd = 0; host_idx = '0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1 reset state
    @(negedge clk); chk("R1 busy", busy, 0);
    op(RI_PTR_LO, 0, 0, "R1", 1); chk("R1 ptr lo", last_act, 0);
    op(RI_PTR_HI, 0, 0, "R1", 1); chk("R1 ptr hi", last_act, 0);
    op(RI_CTRL, 0, 0, "R1", 1); chk("R1 ctrl", last_act, 0);

    // R2 pointer halves, R9 single-cycle register write
    op(RI_PTR_HI, 1, 16'h1234, "R2", 0); chk("R9 ptr write waits", last_waits, 0);
    op(RI_PTR_HI, 0, 0, "R2", 1);
    op(RI_PTR_LO, 1, 16'h0010, "R2", 0);
    op(RI_PTR_LO, 0, 0, "R2", 1);
    set_ptr(32'd5);

    // R3/R5 data block with increment
    op(RI_CTRL, 1, 16'h0001, "R5", 0);
    repeat (2) @(negedge clk);
    op(RI_DATA, 1, 16'hA001, "R3", 0); chk("R9 data write waits", last_waits, 0);
    op(RI_DATA, 1, 16'hA002, "R3", 0);
    op(RI_DATA, 1, 16'hA003, "R3", 0);
    op(RI_PTR_LO, 0, 0, "R5", 1); chk("R5 data step", last_act, 16'd8);
    set_ptr(32'd5);
    repeat (2) @(negedge clk);
    op(RI_DATA, 0, 0, "R3", 1); chk("R3 word", last_act, 16'hA001);
    chk("R8 busy seen", last_bsy, 1); chk("R8 read stall", last_waits, 3);
    op(RI_DATA, 0, 0, "R3", 1); chk("R3 word", last_act, 16'hA002);
    op(RI_DATA, 0, 0, "R3", 1); chk("R3 word", last_act, 16'hA003);

    // R6 increment off, I/O bit alone
    op(RI_CTRL, 1, 16'h0000, "R6", 0);
    set_ptr(32'd9);
    op(RI_DATA, 1, 16'h5A5A, "R6", 0);
    op(RI_PTR_LO, 0, 0, "R6", 1); chk("R6 no advance", last_act, 16'd9);
    op(RI_CTRL, 1, 16'h0002, "R6", 0);
    op(RI_DATA, 0, 0, "R6", 1); chk("R6 word", last_act, 16'h5A5A);
    op(RI_PTR_LO, 0, 0, "R6", 1); chk("R6 io bit no advance", last_act, 16'd9);
    op(RI_CTRL, 0, 0, "R6", 1); chk("R6 ctrl readback", last_act, 16'h0002);

    // R4/R5 instruction words
    op(RI_CTRL, 1, 16'h0001, "R5", 0);
    set_ptr(32'h0040_000C);
    op(RI_ILOW, 1, 16'h1111, "R4", 0);
    op(RI_PTR_LO, 0, 0, "R5", 1); chk("R5 low half no advance", last_act, 16'h000C);
    op(RI_DATA, 1, 16'h2222, "R4", 0);
    op(RI_PTR_LO, 0, 0, "R5", 1); chk("R5 instr step", last_act, 16'h0010);
    chk("R4 low placement", smem[mix(32'h0040_000C)], 16'h1111);
    chk("R4 high placement", smem[mix(32'h0040_000E)], 16'h2222);
    set_ptr(32'h0040_000C);
    op(RI_ILOW, 0, 0, "R4", 1); chk("R4 low read", last_act, 16'h1111);
    op(RI_DATA, 0, 0, "R4", 1); chk("R4 high read", last_act, 16'h2222);

    // R7 read-and-clear
    set_ptr(32'd20);
    op(RI_DATA, 1, 16'hBEEF, "R7", 0);
    set_ptr(32'd20);
    repeat (2) @(negedge clk);
    op(RI_RCLR, 0, 0, "R7", 1); chk("R7 value", last_act, 16'hBEEF);
    chk("R8 clear stall", last_waits, 4);
    op(RI_PTR_LO, 0, 0, "R5", 1); chk("R5 clear step", last_act, 16'd21);
    chk("R7 zeroed", smem[mix(32'd20)], 16'h0000);
    set_ptr(32'd30);
    op(RI_DATA, 1, 16'h1357, "R7", 0);
    set_ptr(32'd30);
    op(RI_RCLR, 1, 16'h5555, "R7", 0);
    op(RI_PTR_LO, 0, 0, "R7", 1); chk("R7 write ignored ptr", last_act, 16'd30);
    op(RI_DATA, 0, 0, "R7", 1); chk("R7 write ignored mem", last_act, 16'h1357);

    // random mix
    for (int k = 0; k < 600; k++) begin
      int r;
      r = int'($urandom % 11);
      case (r)
        0: set_ptr(32'($urandom % 100));
        1: set_ptr(32'h0040_0000 | 32'(($urandom % 24) << 2));
        2: op(RI_CTRL, 1, 16'($urandom % 4), "R6", 0);
        3, 4: op(RI_DATA, 1, 16'($urandom), "R3", 0);
        5: op(RI_ILOW, 1, 16'($urandom), "R4", 0);
        6, 7: op(RI_DATA, 0, 0, ref_ptr[22] ? "R4" : "R3", 1);
        8: op(RI_ILOW, 0, 0, "R4", 1);
        9: op(RI_RCLR, 0, 0, "R7", 1);
        default: op(RI_PTR_LO, 0, 0, "R5", 1);
      endcase
    end
    op(RI_PTR_HI, 0, 0, "R5", 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule